// File: doc/BRIEF.md
# UART Receiver with Flag-Tagged Receive Queue

This block recovers characters from an asynchronous serial input. A clock enable that pulses sixteen times per bit period paces every decision. The receiver finds a start bit, then collects 5 to 8 data bits with the least significant bit first. An optional parity bit and one stop bit follow. Static configuration inputs select the word length and the parity.

Each finished character goes into a receive store, together with a parity-error flag, a stop-error flag and a line-break flag. In queue mode the store holds sixteen characters in arrival order. In single mode it holds one character. A read strobe removes the oldest character. The character and its three flags are visible at the read outputs for as long as the store is not empty.

A level interrupt tells the host that data is waiting. In single mode it follows the occupancy of the one register. In queue mode it compares the fill level with a selectable threshold. When a character arrives and the store is already full, the character is dropped and a sticky overrun flag is raised.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: A start is taken only on a high-to-low change of the synchronised line seen at a `tick_en` pulse. The start is confirmed at the 8th oversample (mid-bit). If the line is high again at that point, the receiver drops back to idle and stores nothing.
- R2: `word_sel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Bits arrive least significant first, each sampled at mid-bit. Unused upper bits of `rd_data` read as zero.
- R3: With `par_on`=1, one parity bit follows the data. `par_even`=1 expects even parity over data plus parity bit, and 0 expects odd. A mismatch sets `rd_perr`. With `par_on`=0, `rd_perr` is always 0.
- R4: Only the first stop bit is checked. If it samples low, `rd_ferr` is set.
- R5: `rd_brk` is set when every data bit, the parity bit (if present) and the stop bit all sample low. The break character is stored once. No new start is taken until the line has been seen high again.
- R6: With `queue_on`=1 the store holds up to 16 characters. They are read back in arrival order, each with its own three flags, and `fill_level` gives the count.
- R7: With `queue_on`=0 the store holds one character.
- R8: A character that arrives while the store is full (16 entries in queue mode, 1 in single mode) is discarded, and `overrun` goes to 1. `overrun` stays at 1 until the next `rd_en` pulse, including a pulse on an empty store.
- R9: In single mode, with `irq_en`=1, `irq` is 1 exactly while a character is held. It falls in the cycle after the read that empties the store.
- R10: In queue mode, with `irq_en`=1, `irq` is 1 exactly while `fill_level` is at or above the threshold. `trig_sel` selects the threshold: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R11: With `irq_en`=0, `irq` stays 0 whatever the fill level.
- R12: `rd_en` removes the oldest character, and `fill_level` and `irq` update at the same clock edge. `rd_en` on an empty store changes nothing except clearing `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| word_sel | input | 2 | Data bit count select (5 + value) |
| par_on | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| queue_on | input | 1 | 1 = 16-entry queue, 0 = single register |
| trig_sel | input | 2 | Queue interrupt threshold select |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Pop the oldest character |
| rd_data | output | 8 | Oldest character, zero-extended |
| rd_perr | output | 1 | Parity error flag of the oldest character |
| rd_ferr | output | 1 | Stop-bit error flag of the oldest character |
| rd_brk | output | 1 | Break flag of the oldest character |
| data_ready | output | 1 | Store holds at least one character |
| fill_level | output | 5 | Number of stored characters |
| overrun | output | 1 | Sticky discard indicator |
| irq | output | 1 | Data-available interrupt |

## Verification
The hardest conditions to reach from the ports are a full 16-entry queue that receives one more character, and a break whose line stays low past the end of the stop bit. A plain stream of frames never produces either.

The stimulus reaches the first by sending seventeen frames with no read in between, while the 14-entry threshold is selected. The irq edge at 14 and the discard at 17 are then checked in the same run. It reaches the second by holding the line low for several bit times after a break frame, and then confirming that exactly one entry was stored. A three-oversample glitch and a read on an empty store cover the cases where the block must do nothing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // One stored character together with its status flags
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       rx_line,
  input  logic [1:0] word_sel,
  input  logic       par_on,
  input  logic       par_even,
  output logic       out_valid,
  output rx_char_t   out_char
);

  localparam int TW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  st_t             state;
  logic [TW-1:0]   tick;
  logic [2:0]      bit_idx;
  logic [2:0]      last_idx;
  logic [7:0]      shreg;
  logic            par_bit;
  logic            line_prev;
  logic            par_calc;
  logic            valid_q;
  rx_char_t        char_q;

  // Two-stage synchroniser on the asynchronous input
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], rx_line};
  end
  assign rx_s = sync_q[SYNC-1];

  assign last_idx = {1'b1, word_sel};
  assign par_calc = par_even ? (^shreg) : ~(^shreg);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tick      <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      line_prev <= 1'b1;
      valid_q   <= 1'b0;
      char_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (tick_en) begin
        line_prev <= rx_s;
        case (state)
          S_IDLE: begin
            if (line_prev && !rx_s) begin
              state <= S_START;
              tick  <= '0;
            end
          end
          S_START: begin
            if (tick == TW'(MID - 2)) begin
              tick <= '0;
              if (!rx_s) begin
                state   <= S_DATA;
                bit_idx <= '0;
                shreg   <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              tick <= tick + 1'b1;
            end
          end
          S_DATA: begin
            if (tick == TW'(OVS - 1)) begin
              tick           <= '0;
              shreg[bit_idx] <= rx_s;
              if (bit_idx == last_idx) state <= par_on ? S_PAR : S_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          S_PAR: begin
            if (tick == TW'(OVS - 1)) begin
              tick    <= '0;
              par_bit <= rx_s;
              state   <= S_STOP;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          S_STOP: begin
            if (tick == TW'(OVS - 1)) begin
              tick        <= '0;
              state       <= S_IDLE;
              valid_q     <= 1'b1;
              char_q.data <= shreg;
              char_q.perr <= par_on && (par_bit != par_calc);
              char_q.ferr <= !rx_s;
              char_q.brk  <= !rx_s && (shreg == 8'd0) && (!par_on || !par_bit);
            end else begin
              tick <= tick + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign out_valid = valid_q;
  assign out_char  = char_q;

  assert_one_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_break_implies_ferr_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_char.brk) |-> out_char.ferr);

  assert_no_perr_without_parity_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(par_on)) |-> !out_char.perr);

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          queue_on,
  input  logic          wr_valid,
  input  rx_char_t      wr_char,
  input  logic          rd_en,
  output rx_char_t      head_char,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          overrun
);

  localparam int AW = $clog2(DEPTH);

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cap;
  logic          full;
  logic          push_ok;
  logic          drop;
  logic          pop;

  assign cap     = queue_on ? CW'(DEPTH) : CW'(1);
  assign full    = (count >= cap);
  assign push_ok = wr_valid && !full;
  assign drop    = wr_valid && full;
  assign pop     = rd_en && (count != '0);

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop)      count_nxt = count + 1'b1;
    else if (!push_ok && pop) count_nxt = count - 1'b1;
  end

  // Storage array without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_char;
  end
  assign head_char = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      count <= count_nxt;
      if (drop)       overrun <= 1'b1;
      else if (rd_en) overrun <= 1'b0;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(wr_valid));

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count == '0 && !wr_valid) |=> (count == '0));

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_en,
  input  logic          queue_on,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] count_nxt,
  output logic          irq
);

  logic [CW-1:0] lvl;
  logic          irq_q;

  always_comb begin
    case (trig_sel)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_en && (queue_on ? (count_nxt >= lvl) : (count_nxt != '0));
  end

  assign irq = irq_q;

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_en) |-> !irq);

endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          rx_line,
  input  logic [1:0]    word_sel,
  input  logic          par_on,
  input  logic          par_even,
  input  logic          queue_on,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          data_ready,
  output logic [CW-1:0] fill_level,
  output logic          overrun,
  output logic          irq
);

  logic          ch_valid;
  rx_char_t      ch;
  rx_char_t      head;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  uart_rx_deser #(.OVS(OVS), .SYNC(2)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .rx_line  (rx_line),
    .word_sel (word_sel),
    .par_on   (par_on),
    .par_even (par_even),
    .out_valid(ch_valid),
    .out_char (ch)
  );

  uart_rx_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .queue_on (queue_on),
    .wr_valid (ch_valid),
    .wr_char  (ch),
    .rd_en    (rd_en),
    .head_char(head),
    .count    (cnt),
    .count_nxt(cnt_nxt),
    .overrun  (overrun)
  );

  uart_rx_irq #(.CW(CW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (irq_en),
    .queue_on (queue_on),
    .trig_sel (trig_sel),
    .count_nxt(cnt_nxt),
    .irq      (irq)
  );

  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign rd_brk     = head.brk;
  assign fill_level = cnt;
  assign data_ready = (cnt != '0);

  assert_irq_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fill_level != '0));

endmodule

// File: tb/tb_uart_rx_fifo_top.sv
module tb_uart_rx_fifo_top;

  localparam int SE_DIV = 4;
  localparam int BITC   = 16 * SE_DIV;

  logic       clk = 0;
  logic       rst = 1;
  logic       tick_en = 0;
  logic       rx_line = 1;
  logic [1:0] word_sel = 2'd3;
  logic       par_on = 0;
  logic       par_even = 0;
  logic       queue_on = 0;
  logic [1:0] trig_sel = 2'd0;
  logic       irq_en = 0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun, irq;
  logic [4:0] fill_level;

  int checks = 0;
  int errors = 0;
  int se_cnt = 0;
  bit cmp_on = 0;
  bit done = 0;

  logic [10:0] mq[$];
  bit          m_ov = 0;

  always #2 clk = ~clk;

  uart_rx_fifo_top dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rx_line(rx_line),
    .word_sel(word_sel), .par_on(par_on), .par_even(par_even),
    .queue_on(queue_on), .trig_sel(trig_sel), .irq_en(irq_en), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .fill_level(fill_level), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit exp_irq();
    if (!irq_en) return 0;
    if (queue_on) return mq.size() >= lvl_of(trig_sel);
    return mq.size() != 0;
  endfunction

  function automatic string irq_tag();
    if (!irq_en) return "R11 irq";
    if (queue_on) return "R10 irq";
    return "R9 irq";
  endfunction

  // Oversampling enable from the bench
  initial begin
    forever begin
      @(negedge clk);
      se_cnt = se_cnt + 1;
      tick_en = (se_cnt % SE_DIV == 0);
    end
  end

  // Per-clock comparison against the reference model while the line is quiet
  initial begin
    forever begin
      @(negedge clk);
      if (cmp_on) begin
        chk("R6 fill_level", fill_level, mq.size());
        chk("R12 data_ready", data_ready, mq.size() != 0);
        chk(irq_tag(), irq, exp_irq());
        chk("R8 overrun", overrun, m_ov);
        if (mq.size() != 0) chk("R2 head entry", {rd_brk, rd_ferr, rd_perr, rd_data}, mq[0]);
      end
    end
  end

  task automatic hold(input logic lv, input int n);
    rx_line = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int nb, input bit pe, input bit pev, input bit q,
                         input logic [1:0] ts, input bit ie);
    cmp_on = 0;
    @(negedge clk);
    word_sel = 2'(nb - 5); par_on = pe; par_even = pev;
    queue_on = q; trig_sel = ts; irq_en = ie;
    @(posedge clk); @(posedge clk); #1;
    cmp_on = 1;
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit bad_par,
                      input logic stop_v, input int low_tail);
    logic [7:0] dm;
    logic p, sent;
    logic perr, ferr, brk;
    int cap;
    dm = d & 8'((1 << nb) - 1);
    cmp_on = 0;
    @(negedge clk);
    hold(1'b0, BITC);
    for (int i = 0; i < nb; i++) hold(dm[i], BITC);
    p = par_even ? ^dm : ~^dm;
    sent = p ^ bad_par;
    if (par_on) hold(sent, BITC);
    hold(stop_v, BITC);
    if (low_tail > 0) hold(1'b0, low_tail);
    hold(1'b1, 2 * BITC);
    perr = par_on && bad_par;
    ferr = !stop_v;
    brk  = !stop_v && (dm == 8'd0) && (!par_on || !sent);
    cap  = queue_on ? 16 : 1;
    @(posedge clk); #1;
    if (mq.size() < cap) mq.push_back({brk, ferr, perr, dm});
    else m_ov = 1;
    cmp_on = 1;
  endtask

  task automatic read_one();
    @(negedge clk);
    cmp_on = 0;
    rd_en = 1;
    @(posedge clk); #1;
    rd_en = 0;
    if (mq.size() != 0) void'(mq.pop_front());
    m_ov = 0;
    cmp_on = 1;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset fill_level R6", fill_level, 0);
    chk("reset irq R9", irq, 0);
    chk("reset overrun R8", overrun, 0);
    chk("reset data_ready R12", data_ready, 0);

    // Single-register mode, 8 data bits, no parity
    set_cfg(8, 0, 0, 0, 2'd0, 1);
    send(8'hA5, 8, 0, 1, 0);
    @(negedge clk);
    chk("R7 single data", rd_data, 8'hA5);
    chk("R9 irq set", irq, 1);
    read_one();
    @(negedge clk);
    chk("R9 irq clear after read", irq, 0);

    // Overrun in single mode
    send(8'h11, 8, 0, 1, 0);
    send(8'h22, 8, 0, 1, 0);
    @(negedge clk);
    chk("R7 first kept", rd_data, 8'h11);
    chk("R8 overrun set", overrun, 1);
    read_one();
    read_one();
    @(negedge clk);
    chk("R12 empty read keeps empty", fill_level, 0);
    chk("R8 overrun cleared", overrun, 0);

    // Queue mode, threshold 4, 7 data bits, even parity
    set_cfg(7, 1, 1, 1, 2'd1, 1);
    send(8'h35, 7, 0, 1, 0);
    send(8'h7F, 7, 1, 1, 0);
    send(8'h01, 7, 0, 1, 0);
    @(negedge clk);
    chk("R10 below threshold", irq, 0);
    chk("R3 no perr on good parity", rd_perr, 0);
    send(8'h40, 7, 0, 1, 0);
    @(negedge clk);
    chk("R10 at threshold", irq, 1);
    read_one();
    @(negedge clk);
    chk("R3 perr flagged", rd_perr, 1);
    chk("R10 below after read", irq, 0);
    while (mq.size() != 0) read_one();

    // 5 data bits, odd parity, stop low
    set_cfg(5, 1, 0, 1, 2'd0, 1);
    send(8'hFF, 5, 0, 0, 0);
    @(negedge clk);
    chk("R2 five bit data", rd_data, 8'h1F);
    chk("R4 ferr on low stop", rd_ferr, 1);
    chk("R5 no brk with data", rd_brk, 0);
    read_one();

    // Break, line held low afterwards
    set_cfg(8, 0, 0, 1, 2'd0, 1);
    send(8'h00, 8, 0, 0, 3 * BITC);
    @(negedge clk);
    chk("R5 single break entry", fill_level, 1);
    chk("R5 brk flag", rd_brk, 1);
    read_one();

    // Glitch shorter than half a bit
    hold(1'b0, 3 * SE_DIV);
    hold(1'b1, 3 * BITC);
    chk("R1 glitch ignored", fill_level, 0);

    // Fill the queue past capacity with threshold 14
    set_cfg(8, 0, 0, 1, 2'd3, 1);
    for (int i = 0; i < 17; i++) begin
      send(8'(8'h30 + i), 8, 0, 1, 0);
      @(negedge clk);
      if (i == 12) chk("R10 irq low at 13", irq, 0);
      if (i == 13) chk("R10 irq high at 14", irq, 1);
    end
    chk("R6 full at 16", fill_level, 16);
    chk("R8 overrun on 17th", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R6 order", rd_data, 8'(8'h30 + i));
      read_one();
    end

    // Interrupt disabled
    set_cfg(8, 0, 0, 0, 2'd0, 0);
    send(8'h5A, 8, 0, 1, 0);
    @(negedge clk);
    chk("R11 irq masked", irq, 0);
    read_one();
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule